// File: doc/BRIEF.md
# Two-Section Binary Ripple Counter

This block is a four-bit binary counter built as two sections that can run on their own. The lower section is one toggle stage. It advances on each falling edge of its count input `tick_lo`. The upper section is a chain of toggle stages, three by default. It advances by one on each falling edge of its own count input `tick_hi`. A parameter can join the two sections: the lower stage's high-to-low transition then advances the upper chain, and the whole block counts 0 to 15 from `tick_lo` alone.

The design is written for a clocked fabric. Both count inputs must be synchronous to `clk`. A falling edge is recognised at the first `clk` edge where the input is seen low after having been high. Every stage that a single event affects changes at that same `clk` edge. As a result, the outputs never pass through an intermediate ripple state.

A clear erases all stages. It acts only when the two clear inputs `clr_a` and `clr_b` are both high. It takes priority over any count event that arrives in the same cycle. The system reset `rst` is synchronous and active high.

Top module: `dual_ripple_counter`

## Requirements
- R1: While `rst` is high at a `clk` edge, `q` becomes 0 at that edge. A count input that is low when reset ends is not counted as an edge.
- R2: In split mode, `q[0]` inverts at each `clk` edge where `tick_lo` was high at the previous edge and is low now. Rising edges and steady levels leave `q[0]` unchanged.
- R3: In split mode, each falling edge of `tick_hi` adds one to `q[3:1]`, read as an unsigned number with `q[1]` as its least significant bit. The value 7 wraps to 0.
- R4: A clear takes effect only when `clr_a` and `clr_b` are both 1 at a `clk` edge. At that edge `q` becomes 0. The combinations (1,0), (0,1) and (0,0) have no effect on counting.
- R5: A count event that meets a clear in the same cycle is discarded, and `q` is 0 after that edge.
- R6: An edge that falls while the clear is active is not counted after the clear is released. The first falling edge after release advances the affected section from 0.
- R7: In joined mode (`MODE = SEC_JOINED`), `q` counts 0, 1, …, 15, 0 in binary with `q[0]` as LSB. It advances once per falling edge of `tick_lo`, and `tick_hi` has no effect.
- R8: In split mode, the two sections are independent. Edges on `tick_lo` never change `q[3:1]`, and edges on `tick_hi` never change `q[0]`.
- R9: All stage changes caused by one event appear at the same `clk` edge. In joined mode, `q` moves from n to (n+1) mod 16 in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples everything |
| rst | input | 1 | Synchronous active-high reset |
| tick_lo | input | 1 | Count input of the single lower stage |
| tick_hi | input | 1 | Count input of the upper chain (ignored when joined) |
| clr_a | input | 1 | First clear input; a clear happens only when both are high |
| clr_b | input | 1 | Second clear input |
| q | output | 4 | Stage states, `q[0]` lower stage, `q[3:1]` upper chain |

## Verification
Three kinds of event can land on the same `clk` edge: a falling edge of `tick_lo`, a falling edge of `tick_hi`, and a clear. The bench drives falling edges on both count inputs in the same cycle in split mode, and checks that each section moves by exactly one step. It also lowers a count input in the very cycle the clear goes high, and checks that the edge is lost rather than counted after release. A second instance runs in joined mode. There, a lower-stage fall that carries into the upper chain is checked against a behavioural integer count every cycle.

// File: rtl/dual_ripple_pkg.sv
package dual_ripple_pkg;
  typedef enum logic {
    SEC_SPLIT  = 1'b0,
    SEC_JOINED = 1'b1
  } join_e;
endpackage

// File: rtl/fall_sense.sv
module fall_sense (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= din;
  end

  assign fall = prev_q & ~din;

  // one event per high-to-low transition: a fall is never reported twice in a row
  assert_single_event_R6: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/toggle_cell.sv
module toggle_cell (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (adv)   q <= ~q;
  end

  assert_cell_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(q));
  assert_cell_flip_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (q != $past(q)));
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  output logic [STAGES-1:0] cnt
);
  logic [STAGES-1:0] en;

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign en[k] = adv;
      end else begin : g_next
        // stage k toggles when every lower stage is about to fall
        assign en[k] = en[k-1] & cnt[k-1];
      end
      toggle_cell u_cell (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .adv (en[k]),
        .q   (cnt[k])
      );
    end
  endgenerate

  assert_chain_step_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (cnt == STAGES'($past(cnt) + 1'b1)));
endmodule

// File: rtl/dual_ripple_counter.sv
module dual_ripple_counter
  import dual_ripple_pkg::*;
#(
  parameter join_e MODE      = SEC_SPLIT,
  parameter int    HI_STAGES = 3,
  localparam int   W         = HI_STAGES + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_lo,
  input  logic         tick_hi,
  input  logic         clr_a,
  input  logic         clr_b,
  output logic [W-1:0] q
);
  logic clear;
  logic fall_lo, fall_hi;
  logic q_lo;
  logic hi_adv;
  logic [HI_STAGES-1:0] q_hi;

  assign clear = clr_a & clr_b;

  fall_sense u_sense_lo (.clk(clk), .rst(rst), .din(tick_lo), .fall(fall_lo));
  fall_sense u_sense_hi (.clk(clk), .rst(rst), .din(tick_hi), .fall(fall_hi));

  toggle_cell u_lo (
    .clk (clk),
    .rst (rst),
    .clr (clear),
    .adv (fall_lo),
    .q   (q_lo)
  );

  generate
    if (MODE == SEC_JOINED) begin : g_joined
      // lower stage about to go high-to-low carries into the chain
      assign hi_adv = fall_lo & q_lo;
    end else begin : g_split
      assign hi_adv = fall_hi;
    end
  endgenerate

  ripple_chain #(.STAGES(HI_STAGES)) u_hi (
    .clk (clk),
    .rst (rst),
    .clr (clear),
    .adv (hi_adv),
    .cnt (q_hi)
  );

  assign q = {q_hi, q_lo};

  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_a && clr_b) |=> (q == '0));
  assert_ignore_hi_R7: assert property (@(posedge clk) disable iff (rst)
    ((MODE == SEC_JOINED) && fall_hi && !fall_lo && !clear) |=> $stable(q));
  assert_joined_step_R9: assert property (@(posedge clk) disable iff (rst)
    ((MODE == SEC_JOINED) && fall_lo && !clear) |=> (q == W'($past(q) + 1'b1)));
  assert_split_upper_R8: assert property (@(posedge clk) disable iff (rst)
    ((MODE == SEC_SPLIT) && !fall_hi && !clear) |=> $stable(q[W-1:1]));
endmodule

// File: tb/dual_ripple_counter_bench.sv
`timescale 1ns/1ps
module dual_ripple_counter_bench;
  import dual_ripple_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tl = 1'b0, th = 1'b0, ca = 1'b0, cb = 1'b0;
  logic [3:0] q_s, q_j;

  int vectors = 0;
  int miscompares = 0;
  bit armed = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model state
  int pl = 0, ph = 0;
  int s_lo = 0, s_hi = 0, j_cnt = 0;

  always #5 clk = ~clk;

  dual_ripple_counter #(.MODE(SEC_SPLIT)) u_dual_ripple_counter (
    .clk(clk), .rst(rst), .tick_lo(tl), .tick_hi(th),
    .clr_a(ca), .clr_b(cb), .q(q_s));

  dual_ripple_counter #(.MODE(SEC_JOINED)) u_dual_ripple_counter_j (
    .clk(clk), .rst(rst), .tick_lo(tl), .tick_hi(th),
    .clr_a(ca), .clr_b(cb), .q(q_j));

  always @(posedge clk) begin
    bit fl, fh;
    fl = (pl == 1) && (tl == 1'b0);
    fh = (ph == 1) && (th == 1'b0);
    if (rst || (ca && cb)) begin
      s_lo = 0; s_hi = 0; j_cnt = 0;
    end else begin
      if (fl) s_lo = 1 - s_lo;
      if (fh) s_hi = (s_hi + 1) % 8;
      if (fl) j_cnt = (j_cnt + 1) % 16;
    end
    if (rst) begin pl = 0; ph = 0; end
    else begin pl = int'(tl); ph = int'(th); end
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      vectors++;
      if (q_s !== 4'(s_hi * 2 + s_lo)) begin
        miscompares++;
        $display("FAIL %s split: q=%0d expected %0d", tag, q_s, s_hi * 2 + s_lo);
      end
      vectors++;
      if (q_j !== 4'(j_cnt)) begin
        miscompares++;
        $display("FAIL %s joined: q=%0d expected %0d", tag, q_j, j_cnt);
      end
    end
  end

  task automatic step(input logic a, input logic b, input logic c1, input logic c2);
    @(negedge clk);
    tl = a; th = b; ca = c1; cb = c2;
  endtask

  initial begin
    // R1: reset with count inputs low, then release
    repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    repeat (2) step(1'b0, 1'b0, 1'b0, 1'b0);
    // R2: lower stage falls, long high levels
    tag = "R2";
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
    end
    // R3: upper chain wraps
    tag = "R3";
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
    end
    // R8: both sections fall together
    tag = "R8";
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
    end
    // R4: single clear inputs do nothing, both clear
    tag = "R4";
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, 1'(i == 0), 1'(i == 1));
      step(1'b0, 1'b0, 1'(i == 0), 1'(i == 1));
    end
    step(1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
    end
    // R5: edge meets clear
    tag = "R5";
    step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    // R6: inputs held low during clear, then released
    tag = "R6";
    step(1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    // R7 / R9: joined wrap with upper input busy
    tag = "R7";
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'(i % 2), 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
    end
    tag = "R9";
    for (int i = 0; i < 17; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
    end
    // R1: reset again mid count
    tag = "R1";
    step(1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    repeat (2) step(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog %s: finished=0 expected 1", tag);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule